// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Stall Unit

This unit sits beside the decode stage of a five-stage in-order integer pipeline. For every source register named by the instruction in decode, it looks at the destinations of the older instructions still in flight in the execute, memory and write-back stages. It finds the youngest one that really writes that register. It then drives the select of the operand-latch multiplexer, so the value is taken from that stage's pipeline register rather than from the stale register file.

Because the register file writes in the same stage as every other write, only read-after-write conflicts are possible, and only those are checked. Two cases cannot be solved by forwarding, and for these the unit raises a stall. The first is a load still in execute whose data is not yet fetched. The second is a branch whose equality compare, done in decode, would need a value that is still in the memory stage. During a stall the surrounding pipeline holds the PC and the decode register, and it sends a bubble with all write enables cleared into execute. The unit itself is combinational. The clock and reset feed only its embedded checks.

Top module: `hazard_bypass_unit`

## Requirements
- R1: Each source select reports the youngest matching writer, with priority execute (code 1) over memory (code 2) over write-back (code 3). Code 0 means the register file.
- R2: A source naming register 0 always selects code 0 and never causes a stall, even when a stage claims to write register 0.
- R3: A stage counts as a writer only when both its valid and its write-enable inputs are high. Otherwise its destination is ignored.
- R4: A source whose use flag is low selects code 0 and causes no stall, whatever the stages hold.
- R5: When the youngest writer of a used source is a load in execute, stall is raised. The select still reports code 1.
- R6: When a non-branch instruction's youngest writer is in the memory stage, the unit forwards with code 2 and does not stall.
- R7: For a branch in decode, a youngest writer in execute that is not a load, or a writer in write-back, is forwarded (code 1 or 3) without a stall.
- R8: For a branch in decode, a used source whose youngest writer is in the memory stage raises stall, and the select reports code 2.
- R9: For a branch in decode, a used source whose youngest writer is a load in execute raises stall.
- R10: The bubble output equals the stall output at all times. Both are low when no rule above asks for a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| id_src | input | NUM_SRC*REG_AW | Source register numbers of the decode instruction, one field per source |
| id_src_use | input | NUM_SRC | High for each source the decode instruction really reads |
| id_branch | input | 1 | Decode instruction is a branch comparing its sources in decode |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_wen | input | 1 | Execute stage instruction writes a register |
| ex_load | input | 1 | Execute stage instruction is a load |
| ex_dst | input | REG_AW | Execute stage destination register |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_wen | input | 1 | Memory stage instruction writes a register |
| mem_dst | input | REG_AW | Memory stage destination register |
| wb_valid | input | 1 | Write-back stage holds a real instruction |
| wb_wen | input | 1 | Write-back stage instruction writes a register |
| wb_dst | input | REG_AW | Write-back stage destination register |
| fwd_sel | output | NUM_SRC*2 | Operand-latch mux select per source (0 file, 1 execute, 2 memory, 3 write-back) |
| stall | output | 1 | Hold the PC and the decode register this cycle |
| bubble | output | 1 | Inject a no-write bubble into execute this cycle |

## Verification
On every cycle the checks confirm several properties. A register-0 or unused source never leaves the file path. A chosen execute or memory path is backed by a real matching writer, and an execute writer always wins over a memory one. A load-use conflict or a branch waiting on the memory stage always stalls, and a stall never appears without a load in execute or a branch facing a memory-stage writer. The exact code chosen when all three stages collide, the rule that only the youngest writer decides whether a branch stalls, and the quiet output for stages with only one of valid or write-enable set are shown by the bench's table and its randomized comparison with a priority model.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
package hzd_pkg;

   typedef enum logic [1:0] {
      SRC_RF  = 2'd0,
      SRC_EX  = 2'd1,
      SRC_MEM = 2'd2,
      SRC_WB  = 2'd3
   } fwd_src_e;

endpackage

// File: rtl/hzd_stage_match.sv
`timescale 1ns/1ps
// Decides whether one pipeline stage is a live writer of one decode source.
module hzd_stage_match #(
   parameter int REG_AW    = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic              stg_valid,
   input  logic              stg_wen,
   input  logic [REG_AW-1:0] stg_dst,
   input  logic              src_use,
   input  logic [REG_AW-1:0] src_reg,
   output logic              hit
);

   logic same_reg;
   logic live_writer;

   assign same_reg    = (stg_dst == src_reg);
   assign live_writer = stg_valid & stg_wen;

   generate
      if (ZERO_HARD) begin : g_zero_hard
         // register 0 is a constant and must never be bypassed
         assign hit = live_writer & src_use & same_reg & (src_reg != '0);
      end else begin : g_zero_soft
         assign hit = live_writer & src_use & same_reg;
      end
   endgenerate

endmodule

// File: rtl/hzd_operand_pick.sv
`timescale 1ns/1ps
// Priority pick of the forwarding path for one source, plus its stall request.
module hzd_operand_pick
   import hzd_pkg::*;
#(
   parameter int REG_AW    = 5,
   parameter bit WB_BYPASS = 1'b1,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_use,
   input  logic [REG_AW-1:0] src_reg,
   input  logic              is_branch,
   input  logic              ex_valid,
   input  logic              ex_wen,
   input  logic              ex_load,
   input  logic [REG_AW-1:0] ex_dst,
   input  logic              mem_valid,
   input  logic              mem_wen,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              wb_valid,
   input  logic              wb_wen,
   input  logic [REG_AW-1:0] wb_dst,
   output fwd_src_e          sel,
   output logic              stall_req
);

   logic hit_ex;
   logic hit_mem;
   logic hit_wb;

   hzd_stage_match #(.REG_AW(REG_AW), .ZERO_HARD(ZERO_HARD)) u_ex (
      .stg_valid (ex_valid),
      .stg_wen   (ex_wen),
      .stg_dst   (ex_dst),
      .src_use   (src_use),
      .src_reg   (src_reg),
      .hit       (hit_ex)
   );

   hzd_stage_match #(.REG_AW(REG_AW), .ZERO_HARD(ZERO_HARD)) u_mem (
      .stg_valid (mem_valid),
      .stg_wen   (mem_wen),
      .stg_dst   (mem_dst),
      .src_use   (src_use),
      .src_reg   (src_reg),
      .hit       (hit_mem)
   );

   generate
      if (WB_BYPASS) begin : g_wb_path
         hzd_stage_match #(.REG_AW(REG_AW), .ZERO_HARD(ZERO_HARD)) u_wb (
            .stg_valid (wb_valid),
            .stg_wen   (wb_wen),
            .stg_dst   (wb_dst),
            .src_use   (src_use),
            .src_reg   (src_reg),
            .hit       (hit_wb)
         );
      end else begin : g_wb_none
         // register file writes early in the cycle, so no path is needed
         logic wb_unused;
         assign wb_unused = &{wb_valid, wb_wen, wb_dst};
         assign hit_wb    = 1'b0 & wb_unused;
      end
   endgenerate

   // youngest writer wins
   always_comb begin
      if (hit_ex)       sel = SRC_EX;
      else if (hit_mem) sel = SRC_MEM;
      else if (hit_wb)  sel = SRC_WB;
      else              sel = SRC_RF;
   end

   // load data not yet fetched, or branch compare cannot reach memory stage
   assign stall_req = (hit_ex & ex_load) | (is_branch & ~hit_ex & hit_mem);

   p_zero_src_rf_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_HARD && src_reg == '0) |-> (sel == SRC_RF && !stall_req));

   p_unused_rf_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !src_use |-> (sel == SRC_RF && !stall_req));

   p_ex_pick_real_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SRC_EX) |-> (ex_valid && ex_wen && ex_dst == src_reg));

   p_mem_pick_real_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SRC_MEM) |-> (mem_valid && mem_wen && mem_dst == src_reg));

   p_ex_beats_mem_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (src_use && src_reg != '0 && ex_valid && ex_wen && ex_dst == src_reg)
      |-> (sel == SRC_EX));

endmodule

// File: rtl/hazard_bypass_unit.sv
`timescale 1ns/1ps
// Top: one operand picker per decode source, stall merged across sources.
module hazard_bypass_unit
   import hzd_pkg::*;
#(
   parameter int REG_AW    = 5,
   parameter int NUM_SRC   = 2,
   parameter bit WB_BYPASS = 1'b1,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_SRC-1:0][REG_AW-1:0]  id_src,
   input  logic [NUM_SRC-1:0]              id_src_use,
   input  logic                            id_branch,
   input  logic                            ex_valid,
   input  logic                            ex_wen,
   input  logic                            ex_load,
   input  logic [REG_AW-1:0]               ex_dst,
   input  logic                            mem_valid,
   input  logic                            mem_wen,
   input  logic [REG_AW-1:0]               mem_dst,
   input  logic                            wb_valid,
   input  logic                            wb_wen,
   input  logic [REG_AW-1:0]               wb_dst,
   output logic [NUM_SRC-1:0][1:0]         fwd_sel,
   output logic                            stall,
   output logic                            bubble
);

   localparam int MAX_SRC = 4;
   localparam int MAX_AW  = 8;

   generate
      if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_src
         $error("hazard_bypass_unit: NUM_SRC out of range");
      end
      if (REG_AW < 1 || REG_AW > MAX_AW) begin : g_bad_aw
         $error("hazard_bypass_unit: REG_AW out of range");
      end
   endgenerate

   fwd_src_e           sel_w [NUM_SRC];
   logic [NUM_SRC-1:0] req_w;

   generate
      for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
         hzd_operand_pick #(
            .REG_AW    (REG_AW),
            .WB_BYPASS (WB_BYPASS),
            .ZERO_HARD (ZERO_HARD)
         ) u_pick (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_use   (id_src_use[gi]),
            .src_reg   (id_src[gi]),
            .is_branch (id_branch),
            .ex_valid  (ex_valid),
            .ex_wen    (ex_wen),
            .ex_load   (ex_load),
            .ex_dst    (ex_dst),
            .mem_valid (mem_valid),
            .mem_wen   (mem_wen),
            .mem_dst   (mem_dst),
            .wb_valid  (wb_valid),
            .wb_wen    (wb_wen),
            .wb_dst    (wb_dst),
            .sel       (sel_w[gi]),
            .stall_req (req_w[gi])
         );

         assign fwd_sel[gi] = sel_w[gi];

         p_load_use_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (id_src_use[gi] && id_src[gi] != '0 && ex_valid && ex_wen && ex_load
             && ex_dst == id_src[gi]) |-> (stall && bubble));

         p_branch_mem_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (id_branch && id_src_use[gi] && id_src[gi] != '0
             && mem_valid && mem_wen && mem_dst == id_src[gi]
             && !(ex_valid && ex_wen && ex_dst == id_src[gi])) |-> stall);
      end
   endgenerate

   assign stall  = |req_w;
   assign bubble = stall;

   p_stall_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> ((ex_valid && ex_wen && ex_load) || (id_branch && mem_valid && mem_wen)));

endmodule

// File: tb/tb_hazard_bypass_unit.sv
`timescale 1ns/1ps
module tb_hazard_bypass_unit;

   localparam int AW = 5;
   localparam int NV = 14;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0][AW-1:0] id_src;
   logic [1:0]      id_src_use;
   logic            id_branch;
   logic            ex_valid, ex_wen, ex_load;
   logic [AW-1:0]   ex_dst;
   logic            mem_valid, mem_wen;
   logic [AW-1:0]   mem_dst;
   logic            wb_valid, wb_wen;
   logic [AW-1:0]   wb_dst;
   logic [1:0][1:0] fwd_sel;
   logic            stall, bubble;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   hazard_bypass_unit #(.REG_AW(AW), .NUM_SRC(2)) dut (
      .clk(clk), .rst_n(rst_n), .id_src(id_src), .id_src_use(id_src_use),
      .id_branch(id_branch), .ex_valid(ex_valid), .ex_wen(ex_wen),
      .ex_load(ex_load), .ex_dst(ex_dst), .mem_valid(mem_valid),
      .mem_wen(mem_wen), .mem_dst(mem_dst), .wb_valid(wb_valid),
      .wb_wen(wb_wen), .wb_dst(wb_dst), .fwd_sel(fwd_sel),
      .stall(stall), .bubble(bubble)
   );

   // fields: srcA srcB useA useB br | exV exW exL exD | mV mW mD | wV wW wD | expA expB expStall | tag
   localparam logic [43:0] VEC [NV] = '{
      {5'd1, 5'd2, 3'b110, 3'b110, 5'd1,  2'b11, 5'd2,  2'b11, 5'd3,  2'd1, 2'd2, 1'b0, 4'd1},
      {5'd5, 5'd5, 3'b110, 3'b110, 5'd5,  2'b11, 5'd5,  2'b11, 5'd5,  2'd1, 2'd1, 1'b0, 4'd1},
      {5'd7, 5'd9, 3'b110, 3'b000, 5'd0,  2'b11, 5'd7,  2'b11, 5'd7,  2'd2, 2'd0, 1'b0, 4'd1},
      {5'd0, 5'd0, 3'b110, 3'b111, 5'd0,  2'b11, 5'd0,  2'b11, 5'd0,  2'd0, 2'd0, 1'b0, 4'd2},
      {5'd4, 5'd4, 3'b110, 3'b010, 5'd4,  2'b10, 5'd4,  2'b11, 5'd4,  2'd3, 2'd3, 1'b0, 4'd3},
      {5'd6, 5'd6, 3'b001, 3'b111, 5'd6,  2'b11, 5'd6,  2'b00, 5'd0,  2'd0, 2'd0, 1'b0, 4'd4},
      {5'd6, 5'd3, 3'b110, 3'b111, 5'd6,  2'b00, 5'd0,  2'b00, 5'd0,  2'd1, 2'd0, 1'b1, 4'd5},
      {5'd8, 5'd8, 3'b110, 3'b110, 5'd9,  2'b11, 5'd8,  2'b11, 5'd8,  2'd2, 2'd2, 1'b0, 4'd6},
      {5'd10,5'd3, 3'b111, 3'b110, 5'd10, 2'b11, 5'd4,  2'b00, 5'd0,  2'd1, 2'd0, 1'b0, 4'd7},
      {5'd2, 5'd11,3'b111, 3'b000, 5'd0,  2'b11, 5'd11, 2'b00, 5'd0,  2'd0, 2'd2, 1'b1, 4'd8},
      {5'd12,5'd1, 3'b111, 3'b111, 5'd12, 2'b00, 5'd0,  2'b00, 5'd0,  2'd1, 2'd0, 1'b1, 4'd9},
      {5'd13,5'd13,3'b111, 3'b110, 5'd13, 2'b11, 5'd13, 2'b00, 5'd0,  2'd1, 2'd1, 1'b0, 4'd7},
      {5'd14,5'd0, 3'b111, 3'b000, 5'd0,  2'b00, 5'd0,  2'b11, 5'd14, 2'd3, 2'd0, 1'b0, 4'd7},
      {5'd1, 5'd2, 3'b111, 3'b000, 5'd0,  2'b00, 5'd0,  2'b00, 5'd0,  2'd0, 2'd0, 1'b0, 4'd10}
   };

   function automatic string tag_name(input int t);
      case (t)
         1: return "R1";   2: return "R2";   3: return "R3";
         4: return "R4";   5: return "R5";   6: return "R6";
         7: return "R7";   8: return "R8";   9: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // reference priority model written from the requirements
   function automatic int ref_sel(input logic use_i, input logic [AW-1:0] s);
      if (!use_i || s == '0) return 0;
      if (ex_valid && ex_wen && ex_dst == s) return 1;
      if (mem_valid && mem_wen && mem_dst == s) return 2;
      if (wb_valid && wb_wen && wb_dst == s) return 3;
      return 0;
   endfunction

   function automatic int ref_stall(input int sa, input int sb);
      int st = 0;
      if ((sa == 1 || sb == 1) && ex_load) st = 1;
      if (id_branch && (sa == 2 || sb == 2)) st = 1;
      return st;
   endfunction

   task automatic idle_inputs();
      id_src = '0; id_src_use = '0; id_branch = 1'b0;
      ex_valid = 1'b0; ex_wen = 1'b0; ex_load = 1'b0; ex_dst = '0;
      mem_valid = 1'b0; mem_wen = 1'b0; mem_dst = '0;
      wb_valid = 1'b0; wb_wen = 1'b0; wb_dst = '0;
   endtask

   initial begin
      idle_inputs();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state with idle stages
      check("R10", "reset stall", int'(stall), 0);
      check("R10", "reset bubble", int'(bubble), 0);
      check("R4", "reset selA", int'(fwd_sel[0]), 0);
      check("R4", "reset selB", int'(fwd_sel[1]), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [43:0] v;
         string r;
         v = VEC[i];
         @(negedge clk);
         id_src[0] = v[43:39]; id_src[1] = v[38:34];
         id_src_use = {v[32], v[33]}; id_branch = v[31];
         ex_valid = v[30]; ex_wen = v[29]; ex_load = v[28]; ex_dst = v[27:23];
         mem_valid = v[22]; mem_wen = v[21]; mem_dst = v[20:16];
         wb_valid = v[15]; wb_wen = v[14]; wb_dst = v[13:9];
         #5;
         r = tag_name(int'(v[3:0]));
         check(r, $sformatf("vec%0d selA", i), int'(fwd_sel[0]), int'(v[8:7]));
         check(r, $sformatf("vec%0d selB", i), int'(fwd_sel[1]), int'(v[6:5]));
         check(r, $sformatf("vec%0d stall", i), int'(stall), int'(v[4]));
         check("R10", $sformatf("vec%0d bubble", i), int'(bubble), int'(v[4]));
      end

      // randomized collisions over four registers against the priority model (R1 R3 R8 R9)
      for (int k = 0; k < 400; k++) begin
         int ea, eb, es;
         @(negedge clk);
         id_src[0] = AW'($urandom_range(0, 3)); id_src[1] = AW'($urandom_range(0, 3));
         id_src_use = 2'($urandom_range(0, 3)); id_branch = 1'($urandom_range(0, 1));
         ex_valid = 1'($urandom_range(0, 1)); ex_wen = 1'($urandom_range(0, 1));
         ex_load = 1'($urandom_range(0, 1)); ex_dst = AW'($urandom_range(0, 3));
         mem_valid = 1'($urandom_range(0, 1)); mem_wen = 1'($urandom_range(0, 1));
         mem_dst = AW'($urandom_range(0, 3));
         wb_valid = 1'($urandom_range(0, 1)); wb_wen = 1'($urandom_range(0, 1));
         wb_dst = AW'($urandom_range(0, 3));
         #5;
         ea = ref_sel(id_src_use[0], id_src[0]);
         eb = ref_sel(id_src_use[1], id_src[1]);
         es = ref_stall(ea, eb);
         check("R1", "rand selA", int'(fwd_sel[0]), ea);
         check("R1", "rand selB", int'(fwd_sel[1]), eb);
         check("R9", "rand stall", int'(stall), es);
         check("R10", "rand bubble", int'(bubble), es);
      end

      @(negedge clk);
      idle_inputs();
      #5;
      check("R10", "idle stall", int'(stall), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1 actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule